// File: doc/BRIEF.md
# Dual-Mode Serial Register Slave

This block is the serial front end of a register-mapped peripheral. A host frames each transaction with an active-high chip enable and moves bits with a serial clock. The block turns that traffic into accesses on a byte-wide parallel register bus. All three serial inputs are brought into the system clock domain through synchronizer flops. A static mode pin selects the wire format. In SPI format, input and output use separate lines and bytes travel most significant bit first. In 3-wire format, input and output share one line and bytes travel least significant bit first. The block drives the output line through a data bit plus an output enable, so the shared line can be resolved outside the block.

Every transaction starts with a header byte that carries a write flag and a register address. One or more data bytes follow. While chip enable stays high the address pointer advances after each data byte, which gives burst access. The pointer wraps inside two regions. The timekeeping region runs from 00h to 1Fh, and the memory region runs from 20h to 7Fh. A one-cycle snapshot strobe tells the external timekeeping logic to copy the running time into a read shadow. It fires when a transaction opens and each time a burst steps from 1Fh back to 00h. The register file and the timekeeping logic sit outside this block.

The serial clock must hold each level for at least four system clock cycles.

Top module: `serial_reg_slave`

## Requirements
- R1: With `spiMode`=1, bytes on `sdi` and `sdo` are most significant bit first. With `spiMode`=0 (3-wire), bytes are least significant bit first and the host reads the block on the same line it drives.
- R2: In SPI format, the level of `sclk` seen when `ce` rises is taken as the idle level. Input bits are sampled on the edge that returns `sclk` to idle. Output bits change on the edge that leaves idle. Both idle levels work.
- R3: In 3-wire format, input bits are sampled on the rising edge of `sclk` and output bits change on the falling edge.
- R4: The first byte after `ce` rises is the header. Its bit 7 is 1 for a write and 0 for a read. Its bits 6:0 are the starting register address.
- R5: When the eighth bit of each write data byte has been sampled, `regWrEn` pulses for exactly one cycle with `regAddr` and `regWrData` valid. `regWrEn` and `regRdEn` are never high together.
- R6: For a read, `regRdEn` pulses for one cycle and the returned `regRdData` is latched before the first output bit of the byte is driven. After every completed data byte, read or write, the pointer advances by one.
- R7: When the pointer is below 20h, it steps from 1Fh to 00h.
- R8: When the pointer is 20h or above, it steps from 7Fh to 20h.
- R9: `snapStrobe` is a one-cycle pulse. It fires once for each rising edge of `ce` and once for each pointer step from 1Fh to 00h.
- R10: `sdoEn` stays low through the header byte and for the whole of a write. It rises only when the first bit of a read byte is driven. It is low again within four cycles of `ce` going low.
- R11: When `ce` goes low in the middle of a byte, the transaction ends and the partial byte is discarded: no write strobe is issued for it.
- R12: After reset, `sdoEn`, `regWrEn`, `regRdEn` and `snapStrobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiMode | input | 1 | Static format select: 1 for SPI, 0 for 3-wire |
| ce | input | 1 | Active-high chip enable that frames a transaction |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (in 3-wire format, the shared line) |
| sdo | output | 1 | Serial data out bit |
| sdoEn | output | 1 | Output enable for `sdo`; low means high impedance |
| regAddr | output | 7 | Register bus address (the burst pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Read data, valid in the same cycle as `regRdEn` |
| snapStrobe | output | 1 | One-cycle pulse to copy live time into the read shadow |

## Verification
The bench covers both SPI idle levels and the 3-wire format. A block that judged the sampling edge wrongly would read every header one bit out of place, and a block with the bit order reversed would write the mirrored byte value, which the later read-back exposes. Bursts that start at 1Eh and 7Eh exercise both wrap points. A pointer that rolled over naturally would step from 7Fh to 00h and overwrite timekeeping registers, and a missed snapshot on the 1Fh step would show up as a short pulse count. An abort after four bits of a data byte catches a block that commits a partial byte. Checks on the output enable during headers and writes catch a block that drives the shared line against the host.

// File: rtl/srs_pkg.sv
package srs_pkg;

  // Per-cycle strobes from the serial control to the datapath
  typedef struct packed {
    logic start;     // chip enable has just risen
    logic clear;     // transaction idle or being restarted
    logic sample;    // take one input bit
    logic shift;     // present the next output bit
    logic addrDone;  // eighth bit of the header byte sampled
    logic dataDone;  // eighth bit of a data byte sampled
    logic bitIn;     // synchronized input data bit
  } srsStrobe_t;

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiMode,
  input  logic       ce,
  input  logic       sclk,
  input  logic       sdi,
  output srsStrobe_t strb
);

  localparam int                CNT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  BIT_LAST = CNT_W'(BYTE_W - 1);

  logic [2:0] rawIn;
  logic [2:0] syncOut;
  logic       ceS, sclkS, sdiS;
  logic       ceD, sclkD;
  logic       idleHigh;
  logic       inHeader;
  logic [CNT_W-1:0] bitCnt;

  assign rawIn = {ce, sclk, sdi};

  srs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .d    (rawIn),
    .q    (syncOut)
  );

  assign {ceS, sclkS, sdiS} = syncOut;

  logic ceRise, active, sclkRise, sclkFall, sampleEdge, shiftEdge, byteEnd;

  always_comb begin
    ceRise   = ceS & ~ceD;
    active   = ceS & ceD;
    sclkRise = sclkS & ~sclkD;
    sclkFall = ~sclkS & sclkD;
    if (spiMode) begin
      // sample on the edge back to idle, shift on the edge leaving idle
      sampleEdge = active & (idleHigh ? sclkRise : sclkFall);
      shiftEdge  = active & (idleHigh ? sclkFall : sclkRise);
    end else begin
      sampleEdge = active & sclkRise;
      shiftEdge  = active & sclkFall;
    end
    byteEnd = sampleEdge & (bitCnt == BIT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceD      <= 1'b0;
      sclkD    <= 1'b0;
      idleHigh <= 1'b0;
      bitCnt   <= '0;
      inHeader <= 1'b1;
    end else begin
      ceD   <= ceS;
      sclkD <= sclkS;
      if (ceRise) idleHigh <= sclkS;
      if (!ceS || ceRise) begin
        bitCnt   <= '0;
        inHeader <= 1'b1;
      end else if (sampleEdge) begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == BIT_LAST) inHeader <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.start    = ceRise;
    strb.clear    = ~ceS | ceRise;
    strb.sample   = sampleEdge;
    strb.shift    = shiftEdge;
    strb.addrDone = byteEnd & inHeader;
    strb.dataDone = byteEnd & ~inHeader;
    strb.bitIn    = sdiS;
  end

endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 7,
  parameter int CLK_LAST  = 'h1F,
  parameter int RAM_FIRST = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiMode,
  input  srsStrobe_t        strb,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  output logic              sdo,
  output logic              sdoEn,
  output logic              snapStrobe
);

  localparam logic [ADDR_W-1:0] PTR_CLK_LAST  = ADDR_W'(CLK_LAST);
  localparam logic [ADDR_W-1:0] PTR_RAM_FIRST = ADDR_W'(RAM_FIRST);
  localparam logic [ADDR_W-1:0] PTR_MAX       = {ADDR_W{1'b1}};

  logic [DATA_W-1:0] rxSh, rxNext, txSh, wrData;
  logic [ADDR_W-1:0] ptr, ptrNext;
  logic wrMode, wrPend, stepPend, fetchPend, txValid;
  logic sdoQ, sdoEnQ, snapQ;

  always_comb begin
    if (spiMode) rxNext = {rxSh[DATA_W-2:0], strb.bitIn};
    else         rxNext = {strb.bitIn, rxSh[DATA_W-1:1]};
    if (ptr == PTR_CLK_LAST)  ptrNext = '0;
    else if (ptr == PTR_MAX)  ptrNext = PTR_RAM_FIRST;
    else                      ptrNext = ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ <= 1'b0;
    end else begin
      snapQ <= strb.start | (stepPend & (ptr == PTR_CLK_LAST));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      txSh      <= '0;
      wrData    <= '0;
      ptr       <= '0;
      wrMode    <= 1'b0;
      wrPend    <= 1'b0;
      stepPend  <= 1'b0;
      fetchPend <= 1'b0;
      txValid   <= 1'b0;
      sdoQ      <= 1'b0;
      sdoEnQ    <= 1'b0;
    end else if (strb.clear) begin
      rxSh      <= '0;
      wrMode    <= 1'b0;
      wrPend    <= 1'b0;
      stepPend  <= 1'b0;
      fetchPend <= 1'b0;
      txValid   <= 1'b0;
      sdoQ      <= 1'b0;
      sdoEnQ    <= 1'b0;
    end else begin
      wrPend    <= 1'b0;
      stepPend  <= 1'b0;
      fetchPend <= 1'b0;
      if (strb.sample) rxSh <= rxNext;
      if (strb.addrDone) begin
        ptr       <= rxNext[ADDR_W-1:0];
        wrMode    <= rxNext[DATA_W-1];
        fetchPend <= ~rxNext[DATA_W-1];
      end
      if (strb.dataDone) begin
        stepPend <= 1'b1;
        wrPend   <= wrMode;
        wrData   <= rxNext;
      end
      if (stepPend) begin
        ptr       <= ptrNext;
        fetchPend <= ~wrMode;
      end
      if (fetchPend) begin
        txSh    <= regRdData;
        txValid <= 1'b1;
      end
      if (strb.shift && txValid) begin
        sdoEnQ <= 1'b1;
        if (spiMode) begin
          sdoQ <= txSh[DATA_W-1];
          txSh <= {txSh[DATA_W-2:0], 1'b0};
        end else begin
          sdoQ <= txSh[0];
          txSh <= {1'b0, txSh[DATA_W-1:1]};
        end
      end
    end
  end

  assign regAddr    = ptr;
  assign regWrEn    = wrPend;
  assign regWrData  = wrData;
  assign regRdEn    = fetchPend;
  assign sdo        = sdoQ;
  assign sdoEn      = sdoEnQ;
  assign snapStrobe = snapQ;

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import srs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int CLK_LAST    = 'h1F,
  parameter int RAM_FIRST   = 'h20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiMode,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  output logic              snapStrobe
);

  srsStrobe_t strb;

  srs_ctrl #(.BYTE_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiMode (spiMode),
    .ce      (ce),
    .sclk    (sclk),
    .sdi     (sdi),
    .strb    (strb)
  );

  srs_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CLK_LAST  (CLK_LAST),
    .RAM_FIRST (RAM_FIRST)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .spiMode    (spiMode),
    .strb       (strb),
    .regRdData  (regRdData),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdEn    (regRdEn),
    .sdo        (sdo),
    .sdoEn      (sdoEn),
    .snapStrobe (snapStrobe)
  );

endmodule

// File: rtl/serial_reg_slave_checker.sv
module serial_reg_slave_checker (
  input logic clk,
  input logic rstN,
  input logic ce,
  input logic sdoEn,
  input logic regWrEn,
  input logic regRdEn,
  input logic snapStrobe
);

  // R5: write strobe lasts one cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5: write and read strobes never overlap
  p_wr_rd_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R6: read strobe lasts one cycle
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  // R9: snapshot strobe lasts one cycle
  p_snap_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    snapStrobe |=> !snapStrobe);

  // R10: output released a few cycles after chip enable falls
  p_hiz_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ce && !$past(ce) && !$past(ce, 2) && !$past(ce, 3)) |-> !sdoEn);

  // R10: output is never driven while a write strobe is issued
  p_no_drive_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sdoEn);

endmodule

bind serial_reg_slave serial_reg_slave_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ce         (ce),
  .sdoEn      (sdoEn),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .snapStrobe (snapStrobe)
);

// File: tb/serial_reg_slave_tb.sv
module serial_reg_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rstN, spiMode, ce, sclk, sdi;
  logic       sdo, sdoEn, regWrEn, regRdEn, snapStrobe;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] mem    [128];
  logic [7:0] expMem [128];
  logic [6:0] logAddr [1024];
  logic [7:0] logData [1024];
  int wrCnt = 0, snapCnt = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit idleH = 1'b0;
  logic [7:0] txData [8];
  logic [7:0] rxData [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .spiMode(spiMode), .ce(ce), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .snapStrobe(snapStrobe)
  );

  assign regRdData = mem[regAddr];

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        mem[regAddr] = regWrData;
        logAddr[wrCnt % 1024] = regAddr;
        logData[wrCnt % 1024] = regWrData;
        wrCnt++;
      end
      if (snapStrobe) snapCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] nextA(input logic [6:0] a);
    if (a == 7'h1F) return 7'h00;
    if (a == 7'h7F) return 7'h20;
    return a + 7'd1;
  endfunction

  task automatic xferBit(input logic b, output logic got, output logic en);
    if (spiMode) begin
      sclk = ~idleH; sdi = b;
      waitClk(HALF);
      got = sdo; en = sdoEn;
      sclk = idleH;
      waitClk(HALF);
    end else begin
      sdi = b;
      waitClk(HALF);
      got = sdo; en = sdoEn;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xferBits(input logic [7:0] v, input int nb, output logic [7:0] got,
                          output bit enAny, output bit enAll);
    logic g, e;
    got = '0; enAny = 0; enAll = 1;
    for (int i = 0; i < nb; i++) begin
      int idx = spiMode ? 7 - i : i;
      xferBit(v[idx], g, e);
      got[idx] = g;
      if (e) enAny = 1; else enAll = 0;
    end
  endtask

  // R1 R2 R3 R4: one framed transaction, checked against the bench model
  task automatic runXfer(input bit wr, input logic [6:0] addr, input int n,
                         input int partBits, input string tag);
    int wrBase, snapBase, wraps;
    logic [7:0] g;
    logic [6:0] a;
    bit enAny, enAll;
    wrBase = wrCnt; snapBase = snapCnt;
    sclk = spiMode ? idleH : 1'b0; sdi = 1'b0;
    waitClk(4);
    ce = 1'b1;
    waitClk(HALF);
    xferBits({wr, addr}, 8, g, enAny, enAll);
    check(!enAny, {tag, " R10 output hi-Z in header"}, int'(enAny), 0);
    for (int k = 0; k < n; k++) begin
      xferBits(wr ? txData[k] : 8'hFF, 8, rxData[k], enAny, enAll);
      if (wr) check(!enAny, {tag, " R10 no drive during write"}, int'(enAny), 0);
      else    check(enAll, {tag, " R10 driven during read byte"}, int'(enAll), 1);
    end
    if (partBits > 0) xferBits(8'hA5, partBits, g, enAny, enAll);
    waitClk(HALF);
    ce = 1'b0;
    waitClk(8);
    check(sdoEn == 1'b0, {tag, " R10 released after ce low"}, int'(sdoEn), 0);
    a = addr; wraps = 0;
    for (int k = 0; k < n; k++) begin
      if (wr) begin
        expMem[a] = txData[k];
        check(logAddr[(wrBase + k) % 1024] == a, {tag, " R5 R6 write address"},
              int'(logAddr[(wrBase + k) % 1024]), int'(a));
        check(logData[(wrBase + k) % 1024] == txData[k], {tag, " R1 R5 write data"},
              int'(logData[(wrBase + k) % 1024]), int'(txData[k]));
      end else begin
        check(rxData[k] == expMem[a], {tag, " R1 R6 read data"},
              int'(rxData[k]), int'(expMem[a]));
      end
      if (a == 7'h1F) wraps++;
      a = nextA(a);
    end
    check(wrCnt - wrBase == (wr ? n : 0), {tag, " R5 R11 write count"},
          wrCnt - wrBase, wr ? n : 0);
    check(snapCnt - snapBase == 1 + wraps, {tag, " R9 snapshot count"},
          snapCnt - snapBase, 1 + wraps);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 7 + 3);
      expMem[i] = mem[i];
    end
    rstN = 1'b0; spiMode = 1'b1; ce = 1'b0; sclk = 1'b0; sdi = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    check(sdoEn == 0, "R12 reset sdoEn", int'(sdoEn), 0);
    check(regWrEn == 0, "R12 reset regWrEn", int'(regWrEn), 0);
    check(regRdEn == 0, "R12 reset regRdEn", int'(regRdEn), 0);
    check(snapStrobe == 0, "R12 reset snapStrobe", int'(snapStrobe), 0);

    // R2 SPI with idle-low clock
    spiMode = 1'b1; idleH = 1'b0;
    txData[0] = 8'h81; txData[1] = 8'h3C; txData[2] = 8'hE7;
    runXfer(1'b1, 7'h40, 3, 0, "R2 spi idle-low write");
    runXfer(1'b0, 7'h40, 3, 0, "R2 spi idle-low read");

    // R2 SPI with idle-high clock
    idleH = 1'b1;
    txData[0] = 8'h12; txData[1] = 8'hF0;
    runXfer(1'b1, 7'h05, 2, 0, "R2 spi idle-high write");
    runXfer(1'b0, 7'h05, 2, 0, "R2 spi idle-high read");

    // R3 3-wire: read back bytes written in SPI format (bit order R1)
    spiMode = 1'b0; idleH = 1'b0;
    runXfer(1'b0, 7'h40, 3, 0, "R3 3wire read of spi data");
    txData[0] = 8'h01; txData[1] = 8'h80;
    runXfer(1'b1, 7'h60, 2, 0, "R3 3wire write");
    spiMode = 1'b1;
    runXfer(1'b0, 7'h60, 2, 0, "R1 spi read of 3wire data");

    // R7 R9 timekeeping region wrap
    txData[0] = 8'hA1; txData[1] = 8'hA2; txData[2] = 8'hA3; txData[3] = 8'hA4;
    runXfer(1'b1, 7'h1E, 4, 0, "R7 clock region wrap write");
    runXfer(1'b0, 7'h1F, 2, 0, "R7 clock region wrap read");

    // R8 memory region wrap
    spiMode = 1'b0;
    txData[0] = 8'hB1; txData[1] = 8'hB2; txData[2] = 8'hB3;
    runXfer(1'b1, 7'h7E, 3, 0, "R8 ram region wrap write");
    runXfer(1'b0, 7'h7E, 3, 0, "R8 ram region wrap read");
    check(mem[0] == expMem[0], "R8 address 00h untouched", int'(mem[0]), int'(expMem[0]));

    // R11 abort in the middle of the second data byte
    spiMode = 1'b1; idleH = 1'b0;
    txData[0] = 8'h5A;
    runXfer(1'b1, 7'h50, 1, 4, "R11 abort partial byte");
    runXfer(1'b0, 7'h50, 2, 0, "R11 partial byte not stored");

    // R4 random transactions across formats and polarities
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      int n;
      spiMode = 1'($urandom % 2);
      idleH = spiMode ? 1'($urandom % 2) : 1'b0;
      a = 7'($urandom % 128);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) txData[k] = 8'($urandom);
      runXfer(1'b1, a, n, 0, "R4 random write");
      spiMode = 1'($urandom % 2);
      idleH = spiMode ? 1'($urandom % 2) : 1'b0;
      runXfer(1'b0, a, n, 0, "R4 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule